// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the host-side sequencer of an SMBus controller. A caller presents one transaction request (kind, 7-bit target address, command byte, length and a single quick bit) and the block breaks it down into the series of bus primitives that the transaction needs: start, repeated start, stop, byte write and byte read with a chosen ACK/NACK. A byte-level I2C engine below it carries out each primitive and answers with a one-cycle completion pulse. For writes it also returns the ACK it saw, and for reads it returns the byte it received.

Thirteen framings are sequenced: quick, send byte, receive byte, write/read byte, write/read word, process call, block write/read, block process call, and the count-less I2C block write/read. Write payload bytes are fetched from the caller by index. Read bytes are streamed out with a valid strobe as they arrive. A completion pulse reports the error flag and the number of data bytes read.

Top module: `smbus_seq`

## Requirements
- R1: Every accepted request starts with a start primitive, then a byte write of the address byte {addr, dir}, where dir (LSB) is 1 for read and 0 for write. Every transaction ends with a stop, followed by a one-cycle `done`. Primitive op codes: 0 start, 1 repeated start, 2 stop, 3 write, 4 read.
- R2: Quick (kind 0) writes only the address byte, with `reqBit` in the LSB, and then stops.
- R3: Read byte (4), read word (6), process call (7), block read (9), block process call (10) and I2C block read (12) write the address with dir 0, then the command byte, then the payload bytes if any, then a repeated start, then the address with dir 1, then the reads. Receive byte (2) reads straight after an address with dir 1.
- R4: Send byte (1) and write byte (3) write payload index 0. Word writes (5, 7) write index 0 (low byte) and then index 1 (high byte). Word reads stream the low byte first.
- R5: Every read primitive requests ACK except the last read of the transaction, which requests NACK.
- R6: Block read (9) takes its first read as a count n, then reads exactly n data bytes. `rdCount` equals n at `done`.
- R7: Block write (8) writes the command, then `reqLen` as a count byte, then payload indices 0 to `reqLen`-1. `reqLen` must be 1 to 32.
- R8: Block process call (10) writes the command, count and 1 to 31 payload bytes. It then reads a count of 1 to 31 and that many data bytes.
- R9: I2C block write (11) and read (12) carry no count byte, and move exactly `reqLen` (1 to 32) payload bytes.
- R10: If a byte write completes with `primAck` low, the next primitive is a stop, after which `done` pulses with `err` set.
- R11: If a returned count is 0 or above the limit (32, or 31 for kind 10), the block sets `err`, performs one discard read with NACK that is not shown on `rdValid`, and then stops.
- R12: A request with a kind above 12, or with a length outside the legal range for its kind, is answered with `done` and `err` one cycle later, and no primitive is issued.
- R13: Each read data byte appears once on `rdData` with `rdValid`. A primitive request stays asserted and unchanged until `primDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle, request accepted |
| reqKind | input | 4 | Transaction kind code (0 to 12) |
| reqAddr | input | 7 | Target address |
| reqCmd | input | 8 | Command byte |
| reqLen | input | 6 | Payload length for length-carrying kinds |
| reqBit | input | 1 | Quick-command data bit |
| wrIdx | output | 6 | Index of the payload byte wanted |
| wrData | input | 8 | Payload byte at `wrIdx` (combinational) |
| primValid | output | 1 | Primitive request |
| primOp | output | 3 | Primitive op code |
| primByte | output | 8 | Byte to write |
| primNack | output | 1 | Read primitive answers NACK |
| primDone | input | 1 | Primitive complete (one cycle) |
| primAck | input | 1 | ACK received on a write |
| primRx | input | 8 | Byte received on a read |
| rdData | output | 8 | Read data byte |
| rdValid | output | 1 | `rdData` valid |
| rdCount | output | 6 | Data bytes read so far |
| done | output | 1 | Transaction finished |
| err | output | 1 | Error flag, valid with `done` |

## Verification
The assertions assume that the engine raises `primDone` only while `primValid` is high, and for exactly one cycle per request. They also assume that `reqValid` is presented only while `reqReady` is high. The bench's engine model waits for a request, adds a small delay that varies, answers once, and then looks for the next request one cycle later. The request driver raises `reqValid` for a single cycle, and only after the previous `done`.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ADDR1, SEL_ADDR2, SEL_CMD, SEL_LEN, SEL_WDATA
  } bsel_e;

  // wMode/rMode: 0 none, 1 one byte, 2 word, 3 request length
  typedef struct packed {
    logic       quick;
    logic       hasCmd;
    logic       wCnt;
    logic       rCnt;
    logic       lim31;
    logic [1:0] wMode;
    logic [1:0] rMode;
  } traits_t;

  typedef struct packed {
    logic  load;
    logic  wInc;
    logic  rInc;
    logic  rdCap;
    logic  cntLoad;
    logic  setErr;
    bsel_e sel;
  } strobe_t;

  function automatic traits_t decodeKind(logic [3:0] k);
    traits_t t;
    t = '0;
    case (k)
      4'd0:  t.quick = 1'b1;
      4'd1:  t.wMode = 2'd1;
      4'd2:  t.rMode = 2'd1;
      4'd3:  begin t.hasCmd = 1'b1; t.wMode = 2'd1; end
      4'd4:  begin t.hasCmd = 1'b1; t.rMode = 2'd1; end
      4'd5:  begin t.hasCmd = 1'b1; t.wMode = 2'd2; end
      4'd6:  begin t.hasCmd = 1'b1; t.rMode = 2'd2; end
      4'd7:  begin t.hasCmd = 1'b1; t.wMode = 2'd2; t.rMode = 2'd2; end
      4'd8:  begin t.hasCmd = 1'b1; t.wCnt = 1'b1; t.wMode = 2'd3; end
      4'd9:  begin t.hasCmd = 1'b1; t.rCnt = 1'b1; end
      4'd10: begin t.hasCmd = 1'b1; t.wCnt = 1'b1; t.wMode = 2'd3;
                   t.rCnt = 1'b1; t.lim31 = 1'b1; end
      4'd11: begin t.hasCmd = 1'b1; t.wMode = 2'd3; end
      4'd12: begin t.hasCmd = 1'b1; t.rMode = 2'd3; end
      default: t = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/smbus_seq_dp.sv
module smbus_seq_dp
  import smbus_seq_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int LEN_W     = $clog2(MAX_BLOCK + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [3:0]       reqKind,
  input  logic [6:0]       reqAddr,
  input  logic [7:0]       reqCmd,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             reqBit,
  input  logic [7:0]       wrData,
  input  logic [7:0]       primRx,
  output logic             reqBad,
  output logic             isQuick,
  output logic             hasCmd,
  output logic             wCnt,
  output logic             hasWrite,
  output logic             rCnt,
  output logic             rdPhase,
  output logic             firstDirRd,
  output logic             wLast,
  output logic             rLast,
  output logic             cntBad,
  output logic [7:0]       primByte,
  output logic [LEN_W-1:0] wrIdx,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic [LEN_W-1:0] rdCount,
  output logic             err
);

  localparam logic [LEN_W-1:0] LIM_FULL  = LEN_W'(MAX_BLOCK);
  localparam logic [LEN_W-1:0] LIM_SHORT = LEN_W'(MAX_BLOCK - 1);
  localparam logic [LEN_W-1:0] ONE       = LEN_W'(1);

  traits_t          trIn, trQ;
  logic [6:0]       addrQ;
  logic [7:0]       cmdQ;
  logic [LEN_W-1:0] lenQ, wIdx, rIdx, rTarget, wTarget, limIn, limQ;
  logic             bitQ, errQ;

  assign trIn  = decodeKind(reqKind);
  assign limIn = trIn.lim31 ? LIM_SHORT : LIM_FULL;
  assign limQ  = trQ.lim31 ? LIM_SHORT : LIM_FULL;

  assign reqBad = (reqKind > 4'd12) ||
                  (((trIn.wMode == 2'd3) || (trIn.rMode == 2'd3)) &&
                   ((reqLen == '0) || (reqLen > limIn)));

  assign isQuick    = trQ.quick;
  assign hasCmd     = trQ.hasCmd;
  assign wCnt       = trQ.wCnt;
  assign hasWrite   = (trQ.wMode != 2'd0);
  assign rCnt       = trQ.rCnt;
  assign rdPhase    = trQ.rCnt || (trQ.rMode != 2'd0);
  assign firstDirRd = trQ.quick ? bitQ : (!trQ.hasCmd && rdPhase);

  always_comb begin
    case (trQ.wMode)
      2'd1:    wTarget = ONE;
      2'd2:    wTarget = LEN_W'(2);
      default: wTarget = lenQ;
    endcase
  end

  assign wLast  = (wIdx + ONE) == wTarget;
  assign rLast  = (rIdx + ONE) == rTarget;
  assign cntBad = (primRx == 8'd0) || (primRx > 8'(limQ));

  always_comb begin
    case (stb.sel)
      SEL_ADDR1: primByte = {addrQ, firstDirRd};
      SEL_ADDR2: primByte = {addrQ, 1'b1};
      SEL_CMD:   primByte = cmdQ;
      SEL_LEN:   primByte = 8'(lenQ);
      SEL_WDATA: primByte = wrData;
      default:   primByte = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trQ     <= '0;
      addrQ   <= '0;
      cmdQ    <= '0;
      lenQ    <= '0;
      bitQ    <= 1'b0;
      wIdx    <= '0;
      rIdx    <= '0;
      rTarget <= '0;
      errQ    <= 1'b0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= 1'b0;
      if (stb.load) begin
        trQ   <= trIn;
        addrQ <= reqAddr;
        cmdQ  <= reqCmd;
        lenQ  <= reqLen;
        bitQ  <= reqBit;
        wIdx  <= '0;
        rIdx  <= '0;
        errQ  <= stb.setErr;
        case (trIn.rMode)
          2'd1:    rTarget <= ONE;
          2'd2:    rTarget <= LEN_W'(2);
          default: rTarget <= reqLen;
        endcase
      end else begin
        if (stb.setErr)  errQ    <= 1'b1;
        if (stb.wInc)    wIdx    <= wIdx + ONE;
        if (stb.rInc)    rIdx    <= rIdx + ONE;
        if (stb.cntLoad) rTarget <= primRx[LEN_W-1:0];
        if (stb.rdCap) begin
          rdData  <= primRx;
          rdValid <= 1'b1;
        end
      end
    end
  end

  assign wrIdx   = wIdx;
  assign rdCount = rIdx;
  assign err     = errQ;

  p_rdcount_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdCount <= LIM_FULL);
  p_rdvalid_counted_r13: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdCount != '0));

endmodule

// File: rtl/smbus_seq_ctrl.sv
module smbus_seq_ctrl
  import smbus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqBad,
  input  logic    isQuick,
  input  logic    hasCmd,
  input  logic    wCnt,
  input  logic    hasWrite,
  input  logic    rCnt,
  input  logic    rdPhase,
  input  logic    wLast,
  input  logic    rLast,
  input  logic    cntBad,
  input  logic    primDone,
  input  logic    primAck,
  output logic    reqReady,
  output logic    primValid,
  output op_e     primOp,
  output logic    primNack,
  output logic    done,
  output strobe_t stb
);

  typedef enum logic [3:0] {
    S_IDLE, S_BEGIN, S_ADDR1, S_CMD, S_WCNT, S_WDATA, S_RSTART,
    S_ADDR2, S_RCNT, S_RDATA, S_DISCARD, S_STOP, S_FIN
  } state_e;

  state_e st, nxt;

  always_comb begin
    stb       = '0;
    stb.sel   = SEL_NONE;
    nxt       = st;
    primValid = 1'b0;
    primOp    = OP_START;
    primNack  = 1'b0;
    case (st)
      S_IDLE: if (reqValid) begin
        stb.load = 1'b1;
        if (reqBad) begin stb.setErr = 1'b1; nxt = S_FIN; end
        else nxt = S_BEGIN;
      end
      S_BEGIN: begin
        primValid = 1'b1;
        if (primDone) nxt = S_ADDR1;
      end
      S_ADDR1: begin
        primValid = 1'b1; primOp = OP_WRITE; stb.sel = SEL_ADDR1;
        if (primDone) begin
          if (!primAck)      begin stb.setErr = 1'b1; nxt = S_STOP; end
          else if (isQuick)  nxt = S_STOP;
          else if (hasCmd)   nxt = S_CMD;
          else if (hasWrite) nxt = S_WDATA;
          else               nxt = S_RDATA;
        end
      end
      S_CMD: begin
        primValid = 1'b1; primOp = OP_WRITE; stb.sel = SEL_CMD;
        if (primDone) begin
          if (!primAck)      begin stb.setErr = 1'b1; nxt = S_STOP; end
          else if (wCnt)     nxt = S_WCNT;
          else if (hasWrite) nxt = S_WDATA;
          else               nxt = S_RSTART;
        end
      end
      S_WCNT: begin
        primValid = 1'b1; primOp = OP_WRITE; stb.sel = SEL_LEN;
        if (primDone) begin
          if (!primAck) begin stb.setErr = 1'b1; nxt = S_STOP; end
          else nxt = S_WDATA;
        end
      end
      S_WDATA: begin
        primValid = 1'b1; primOp = OP_WRITE; stb.sel = SEL_WDATA;
        if (primDone) begin
          if (!primAck) begin stb.setErr = 1'b1; nxt = S_STOP; end
          else begin
            stb.wInc = 1'b1;
            if (wLast) nxt = rdPhase ? S_RSTART : S_STOP;
          end
        end
      end
      S_RSTART: begin
        primValid = 1'b1; primOp = OP_RSTART;
        if (primDone) nxt = S_ADDR2;
      end
      S_ADDR2: begin
        primValid = 1'b1; primOp = OP_WRITE; stb.sel = SEL_ADDR2;
        if (primDone) begin
          if (!primAck)  begin stb.setErr = 1'b1; nxt = S_STOP; end
          else if (rCnt) nxt = S_RCNT;
          else           nxt = S_RDATA;
        end
      end
      S_RCNT: begin
        primValid = 1'b1; primOp = OP_READ;
        if (primDone) begin
          if (cntBad) begin stb.setErr = 1'b1; nxt = S_DISCARD; end
          else begin stb.cntLoad = 1'b1; nxt = S_RDATA; end
        end
      end
      S_RDATA: begin
        primValid = 1'b1; primOp = OP_READ; primNack = rLast;
        if (primDone) begin
          stb.rdCap = 1'b1; stb.rInc = 1'b1;
          if (rLast) nxt = S_STOP;
        end
      end
      S_DISCARD: begin
        primValid = 1'b1; primOp = OP_READ; primNack = 1'b1;
        if (primDone) nxt = S_STOP;
      end
      S_STOP: begin
        primValid = 1'b1; primOp = OP_STOP;
        if (primDone) nxt = S_FIN;
      end
      S_FIN:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  assign reqReady = (st == S_IDLE);
  assign done     = (st == S_FIN);

  p_hold_req_r13: assert property (@(posedge clk) disable iff (!rstN)
    (primValid && !primDone) |=> (primValid && $stable(primOp) && $stable(primNack)));
  p_nack_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    (primValid && primDone && primOp == OP_WRITE && !primAck) |=> (primValid && primOp == OP_STOP));
  p_start_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqBad) |=> (primValid && primOp == OP_START));
  p_reject_r12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqBad) |=> (done && !primValid));

endmodule

// File: rtl/smbus_seq.sv
module smbus_seq
  import smbus_seq_pkg::*;
#(
  parameter int MAX_BLOCK = 32,
  parameter int LEN_W     = $clog2(MAX_BLOCK + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [3:0]       reqKind,
  input  logic [6:0]       reqAddr,
  input  logic [7:0]       reqCmd,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             reqBit,
  output logic [LEN_W-1:0] wrIdx,
  input  logic [7:0]       wrData,
  output logic             primValid,
  output logic [2:0]       primOp,
  output logic [7:0]       primByte,
  output logic             primNack,
  input  logic             primDone,
  input  logic             primAck,
  input  logic [7:0]       primRx,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic [LEN_W-1:0] rdCount,
  output logic             done,
  output logic             err
);

  strobe_t stb;
  op_e     opInt;
  logic    reqBad, isQuick, hasCmd, wCnt, hasWrite, rCnt, rdPhase;
  logic    firstDirRd, wLast, rLast, cntBad;

  smbus_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBad(reqBad),
    .isQuick(isQuick), .hasCmd(hasCmd), .wCnt(wCnt), .hasWrite(hasWrite),
    .rCnt(rCnt), .rdPhase(rdPhase), .wLast(wLast), .rLast(rLast),
    .cntBad(cntBad), .primDone(primDone), .primAck(primAck),
    .reqReady(reqReady), .primValid(primValid), .primOp(opInt),
    .primNack(primNack), .done(done), .stb(stb)
  );

  smbus_seq_dp #(.MAX_BLOCK(MAX_BLOCK), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqCmd(reqCmd), .reqLen(reqLen), .reqBit(reqBit), .wrData(wrData),
    .primRx(primRx), .reqBad(reqBad), .isQuick(isQuick), .hasCmd(hasCmd),
    .wCnt(wCnt), .hasWrite(hasWrite), .rCnt(rCnt), .rdPhase(rdPhase),
    .firstDirRd(firstDirRd), .wLast(wLast), .rLast(rLast), .cntBad(cntBad),
    .primByte(primByte), .wrIdx(wrIdx), .rdData(rdData), .rdValid(rdValid),
    .rdCount(rdCount), .err(err)
  );

  assign primOp = opInt;

endmodule

// File: tb/smbus_seq_bench.sv
// Coverage: R1 framing, R2 quick, R3 restart order, R4 word order, R5 last-read NACK,
// R6 block read count, R7 block write, R8 block process call, R9 count-less block,
// R10 NACK abort, R11 bad returned count, R12 rejected request, R13 streaming/handshake.
module smbus_seq_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [3:0] reqKind = '0;
  logic [6:0] reqAddr = '0;
  logic [7:0] reqCmd = '0;
  logic [5:0] reqLen = '0;
  logic       reqBit = 1'b0;
  logic [5:0] wrIdx;
  logic [7:0] wrData;
  logic       primValid;
  logic [2:0] primOp;
  logic [7:0] primByte;
  logic       primNack;
  logic       primDone = 1'b0;
  logic       primAck = 1'b1;
  logic [7:0] primRx = '0;
  logic [7:0] rdData;
  logic       rdValid;
  logic [5:0] rdCount;
  logic       done;
  logic       err;
  logic [7:0] curSeed = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign wrData = 8'(wrIdx * 13) ^ curSeed;

  smbus_seq u_smbus_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqCmd(reqCmd), .reqLen(reqLen),
    .reqBit(reqBit), .wrIdx(wrIdx), .wrData(wrData), .primValid(primValid),
    .primOp(primOp), .primByte(primByte), .primNack(primNack),
    .primDone(primDone), .primAck(primAck), .primRx(primRx),
    .rdData(rdData), .rdValid(rdValid), .rdCount(rdCount), .done(done), .err(err)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // engine model and logs
  logic [2:0] logOp [0:127];
  logic [7:0] logByte [0:127];
  logic       logNack [0:127];
  int         logN = 0;
  logic [7:0] rdBytes [0:63];
  int         rdPtr = 0;
  int         wrCnt = 0;
  int         nackAt = -1;
  int         engWait = 0;
  bit         engBusy = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      primDone = 1'b0;
      engBusy = 0;
    end else begin
      primDone = 1'b0;
      if (engBusy) begin
        if (engWait > 0) engWait--;
        else begin
          engBusy = 0;
          primDone = 1'b1;
          if (logN < 128) begin
            logOp[logN]   = primOp;
            logByte[logN] = (primOp == 3'd3) ? primByte : 8'd0;
            logNack[logN] = (primOp == 3'd4) ? primNack : 1'b0;
          end
          logN++;
          if (primOp == 3'd3) begin primAck = (wrCnt != nackAt); wrCnt++; end
          if (primOp == 3'd4) begin primRx = rdBytes[rdPtr % 64]; rdPtr++; end
        end
      end else if (primValid) begin
        engBusy = 1;
        engWait = logN % 3;
      end
    end
  end

  logic [7:0] got [0:63];
  int  gotN = 0;
  bit  doneSeen = 0;
  int  doneCnt = 0;
  bit  doneErr = 0;

  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (gotN < 64) got[gotN] = rdData;
      gotN++;
    end
    if (rstN && done) begin
      doneSeen = 1;
      doneCnt = rdCount;
      doneErr = err;
    end
  end

  // expected model
  logic [2:0] eOp [0:127];
  logic [7:0] eByte [0:127];
  logic       eNack [0:127];
  int         eN;
  logic [7:0] eRd [0:63];
  int         eRdN;
  bit         eErr, ab;
  int         eWn;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic ePush(input logic [2:0] op, input logic [7:0] b, input logic nk);
    if (eN < 128) begin eOp[eN] = op; eByte[eN] = b; eNack[eN] = nk; end
    eN++;
  endtask
  task automatic eW(input logic [7:0] b);
    if (!ab) begin
      ePush(3'd3, b, 1'b0);
      if (eWn == nackAt) begin ab = 1; ePush(3'd2, 8'd0, 1'b0); end
      eWn++;
    end
  endtask
  task automatic eO(input logic [2:0] op);
    if (!ab) ePush(op, 8'd0, 1'b0);
  endtask
  task automatic eR(input logic nk);
    if (!ab) ePush(3'd4, 8'd0, nk);
  endtask

  task automatic runTxn(input int kind, input int len, input bit bitv, input int devCnt,
                        input int nackPos, input int seed, input string tag);
    bit bad, hasCmd, rd;
    int lim, wn, n, base, k;
    logic [6:0] addr;
    logic [7:0] cmd;
    addr = 7'(7'h11 + seed * 3);
    cmd  = 8'(8'h40 + seed);
    curSeed = 8'(seed * 29);
    nackAt = nackPos;
    for (int j = 0; j < 64; j++) rdBytes[j] = 8'(8'h30 + j * 5 + seed);
    if (kind == 9 || kind == 10) rdBytes[0] = 8'(devCnt);
    logN = 0; rdPtr = 0; wrCnt = 0; gotN = 0; doneSeen = 0;
    eN = 0; eRdN = 0; eErr = 0; ab = 0; eWn = 0;
    lim = (kind == 10) ? 31 : 32;
    bad = (kind > 12) || ((kind == 8 || kind == 10 || kind == 11 || kind == 12) &&
                          (len == 0 || len > lim));
    if (bad) eErr = 1;
    else begin
      eO(3'd0);
      eW({addr, (kind == 0) ? bitv : (kind == 2)});
      hasCmd = (kind >= 3);
      if (hasCmd) eW(cmd);
      case (kind)
        1, 3: wn = 1;
        5, 7: wn = 2;
        8, 10, 11: wn = len;
        default: wn = 0;
      endcase
      if (kind == 8 || kind == 10) eW(8'(len));
      for (int i = 0; i < wn; i++) eW(8'(i * 13) ^ curSeed);
      rd = (kind == 2 || kind == 4 || kind == 6 || kind == 7 || kind == 9 || kind == 10 || kind == 12);
      if (rd && hasCmd) begin eO(3'd1); eW({addr, 1'b1}); end
      n = 0; base = 0;
      if (rd) begin
        if (kind == 9 || kind == 10) begin
          eR(1'b0);
          base = 1;
          if (devCnt == 0 || devCnt > lim) begin
            eR(1'b1);
            if (!ab) eErr = 1;
          end else n = devCnt;
        end else begin
          case (kind)
            2, 4: n = 1;
            6, 7: n = 2;
            default: n = len;
          endcase
        end
      end
      for (int i = 0; i < n; i++) begin
        eR(i == n - 1);
        if (!ab) begin eRd[eRdN] = rdBytes[base + i]; eRdN++; end
      end
      eO(3'd2);
      if (ab) eErr = 1;
    end
    @(negedge clk);
    reqKind = 4'(kind); reqAddr = addr; reqCmd = cmd; reqLen = 6'(len); reqBit = bitv;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    k = 0;
    while (!doneSeen && k < 3000) begin @(posedge clk); k++; end
    chk(doneSeen, tag, "done seen", doneSeen, 1);
    // primitive sequence
    begin
      int bad_i;
      bad_i = -1;
      if (logN != eN) bad_i = (logN < eN) ? logN : eN;
      for (int i = 0; i < eN && i < logN && i < 128; i++)
        if (bad_i < 0 && (logOp[i] != eOp[i] || logByte[i] != eByte[i] || logNack[i] != eNack[i]))
          bad_i = i;
      if (bad_i >= 0 && bad_i < 128 && bad_i < logN && bad_i < eN)
        chk(0, tag, "primitive op/byte/nack at index", {logOp[bad_i], logByte[bad_i], logNack[bad_i]},
            {eOp[bad_i], eByte[bad_i], eNack[bad_i]});
      else chk(bad_i < 0, tag, "primitive count", logN, eN);
    end
    begin
      int mis;
      mis = (gotN != eRdN) ? 1 : 0;
      for (int i = 0; i < eRdN && i < gotN && i < 64; i++) if (got[i] != eRd[i]) mis = 1;
      chk(mis == 0, tag, "read stream length", gotN, eRdN);
    end
    chk(doneCnt == eRdN, tag, "rdCount at done", doneCnt, eRdN);
    chk(doneErr == eErr, tag, "err at done", doneErr, eErr);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady == 1 && primValid == 0 && done == 0 && rdValid == 0, "R13", "reset state",
        {reqReady, primValid, done, rdValid}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    // R2 quick
    runTxn(0, 0, 1'b0, 0, -1, 1, "R2");
    runTxn(0, 0, 1'b1, 0, -1, 2, "R2");
    // R1 simple framings, R3 restart, R4 word order, R5 NACK last
    runTxn(1, 0, 1'b0, 0, -1, 3, "R1");
    runTxn(2, 0, 1'b0, 0, -1, 4, "R5");
    runTxn(3, 0, 1'b0, 0, -1, 5, "R4");
    runTxn(4, 0, 1'b0, 0, -1, 6, "R3");
    runTxn(5, 0, 1'b0, 0, -1, 7, "R4");
    runTxn(6, 0, 1'b0, 0, -1, 8, "R4");
    runTxn(7, 0, 1'b0, 0, -1, 9, "R3");
    // R7 block write sweep
    for (int l = 1; l <= 32; l++) runTxn(8, l, 1'b0, 0, -1, l, "R7");
    // R6 block read sweep
    for (int c = 1; c <= 32; c++) runTxn(9, 0, 1'b0, c, -1, c + 40, "R6");
    // R11 bad returned counts
    runTxn(9, 0, 1'b0, 0, -1, 11, "R11");
    runTxn(9, 0, 1'b0, 33, -1, 12, "R11");
    runTxn(9, 0, 1'b0, 200, -1, 13, "R11");
    runTxn(10, 4, 1'b0, 32, -1, 14, "R11");
    runTxn(10, 4, 1'b0, 0, -1, 15, "R11");
    // R8 block process call
    for (int l = 1; l <= 31; l++) runTxn(10, l, 1'b0, 32 - l, -1, l + 80, "R8");
    // R9 count-less I2C blocks
    for (int l = 1; l <= 32; l++) runTxn(11, l, 1'b0, 0, -1, l + 120, "R9");
    for (int l = 1; l <= 32; l++) runTxn(12, l, 1'b0, 0, -1, l + 160, "R9");
    // R12 rejected requests
    runTxn(8, 0, 1'b0, 0, -1, 16, "R12");
    runTxn(8, 33, 1'b0, 0, -1, 17, "R12");
    runTxn(10, 32, 1'b0, 5, -1, 18, "R12");
    runTxn(11, 0, 1'b0, 0, -1, 19, "R12");
    runTxn(12, 40, 1'b0, 0, -1, 20, "R12");
    runTxn(13, 4, 1'b0, 0, -1, 21, "R12");
    runTxn(15, 4, 1'b0, 0, -1, 22, "R12");
    // R10 NACK on each written byte
    for (int p = 0; p < 5; p++) runTxn(7, 0, 1'b0, 0, p, p + 200, "R10");
    runTxn(0, 0, 1'b1, 0, 0, 23, "R10");
    runTxn(8, 5, 1'b0, 0, 2, 24, "R10");
    runTxn(8, 5, 1'b0, 0, 6, 25, "R10");
    runTxn(9, 0, 1'b0, 4, 2, 26, "R10");
    // R13 streaming after aborts: normal transaction still clean
    runTxn(6, 0, 1'b0, 0, -1, 27, "R13");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule